// File: doc/BRIEF.md
# Gated prescaled 16-bit timer

This block is a 16-bit up-counting timer with a programmable period. A 16-bit control word chooses between the internal instruction clock and one of four extended tick sources. It sets a prescale ratio of 1, 8, 64 or 256 and can enable gated accumulation, in which the internal clock is counted only while a gate input is high. Extended sources can pass through a two-flop synchroniser with rising-edge detection. A stop-in-idle option freezes the timer while an idle input is asserted.

Software uses one write port and one combinational read port. Address 0 holds the control word, address 1 the counter, address 2 the period, and address 3 reads as zero. When the counter equals the period and a prescaled tick arrives, the counter returns to zero and `irq_pulse` is high for one cycle. In gated mode, a falling edge of the gate gives a one-cycle `gate_done` pulse. Every input is sampled in the system clock domain. The internal instruction clock is the system clock itself, so it gives one tick in every cycle.

Top module: `gtmr16_top`

## Requirements
- R1: After synchronous reset, the control word and counter read 0, the period reads 16'hFFFF, and `irq_pulse` and `gate_done` are low.
- R2: Address 0 is the control word, 1 the counter, 2 the period, and 3 reads 0. Writes take effect at the next clock edge. Control bits 14, 12, 11, 10, 6, 3 and 0 always read 0, so writing 16'hFFFF reads back as 16'hA3B6.
- R3: Control bits [5:4] set the prescale ratio: 00 gives one count per tick, 01 one per 8 ticks, 10 one per 64 and 11 one per 256.
- R4: With bit 15 set and bit 1 clear, the internal source supplies one tick per clock cycle. With bit 15 clear, the counter holds its value.
- R5: With bit 1 set, control bits [9:8] select `ext_clk_en[0..3]`. With bit 2 clear, every cycle in which the selected input is high is one tick.
- R6: With bits 1 and 2 set, each rising edge of the selected input gives exactly one tick. A high level sampled at edge k is counted at edge k+2.
- R7: Bit 7 enables gating. When it is set and bit 1 is clear, internal ticks count only in cycles where `gate_in` is high. In that mode, when the timer is running, a high-to-low change of `gate_in` raises `gate_done` for one cycle. Bit 7 is ignored on extended sources.
- R8: Bit 2 has no effect when the internal source is selected.
- R9: A prescaled tick while the counter equals the period sets the counter to 0 and raises `irq_pulse` in the following cycle. Any other tick adds 1 to the counter.
- R10: With bit 13 set, the timer makes no progress in cycles where `idle_in` is high. With bit 13 clear, `idle_in` is ignored.
- R11: A counter write loads the value at once and clears the prescaler. A control write while bit 15 is set clears the prescaler. No tick is counted in a cycle that writes the control word or the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| ext_clk_en | input | 4 | Extended tick strobes, one per source |
| gate_in | input | 1 | Gate for accumulation mode |
| idle_in | input | 1 | Idle indication |
| irq_pulse | output | 1 | One-cycle period-match pulse |
| gate_done | output | 1 | One-cycle gate falling-edge pulse |

## Verification
The counter is driven from the internal source at all four prescale ratios, with the period both left at its default and set small, so that ratio errors and wrap errors show up separately. Random strobe patterns go to all four extended inputs with synchronisation both off and on. Because each input carries a different pattern, a wrong source select becomes visible, and counting levels rather than edges gives a different count. A toggled gate, run under gated mode and again under an extended source, separates gating from the ignore rule. Idle toggling with the stop bit set and then cleared, together with control and counter writes in the middle of a prescale cycle, exposes errors in the prescaler clear and in write priority.

// File: rtl/gtmr16_pkg.sv
package gtmr16_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 2;
    localparam int NUM_EXT = 4;
    localparam int SEL_W   = $clog2(NUM_EXT);
    localparam int PRE_W   = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_COUNT  = 2'd1,
        REG_PERIOD = 2'd2,
        REG_NONE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             run;
        logic             rsv14;
        logic             idle_stop;
        logic [2:0]       rsv12_10;
        logic [SEL_W-1:0] ext_sel;
        logic             gate_en;
        logic             rsv6;
        logic [1:0]       pre_sel;
        logic             rsv3;
        logic             sync_en;
        logic             src_ext;
        logic             rsv0;
    } ctrl_t;

    localparam logic [DATA_W-1:0] CTRL_MASK = 16'hA3B6;

    function automatic logic [PRE_W-1:0] pre_last(input logic [1:0] sel);
        case (sel)
            2'd0:    pre_last = PRE_W'(0);
            2'd1:    pre_last = PRE_W'(7);
            2'd2:    pre_last = PRE_W'(63);
            default: pre_last = PRE_W'(255);
        endcase
    endfunction

endpackage

// File: rtl/gtmr16_src.sv
module gtmr16_src
    import gtmr16_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EXT-1:0] ext_in,
    input  logic [SEL_W-1:0]   ext_sel,
    input  logic               src_ext,
    input  logic               sync_en,
    input  logic               gate_en,
    input  logic               gate_in,
    output logic               tick
);
    logic [NUM_EXT-1:0] rise_v;

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_sync
        logic [2:0] shreg;
        always_ff @(posedge clk) begin
            if (rst) shreg <= '0;
            else     shreg <= {shreg[1:0], ext_in[i]};
        end
        assign rise_v[i] = shreg[1] & ~shreg[2];
    end

    always_comb begin
        if (src_ext)      tick = sync_en ? rise_v[ext_sel] : ext_in[ext_sel];
        else if (gate_en) tick = gate_in;
        else              tick = 1'b1;
    end
endmodule

// File: rtl/gtmr16_presc.sv
module gtmr16_presc
    import gtmr16_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [PRE_W-1:0] last,
    output logic             ptick
);
    logic [PRE_W-1:0] pcnt;

    assign ptick = adv && (pcnt == last);

    always_ff @(posedge clk) begin
        if (rst || clr)  pcnt <= '0;
        else if (ptick)  pcnt <= '0;
        else if (adv)    pcnt <= pcnt + PRE_W'(1);
    end
endmodule

// File: rtl/gtmr16_cnt.sv
module gtmr16_cnt
    import gtmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              step,
    input  logic [DATA_W-1:0] period,
    output logic [DATA_W-1:0] count,
    output logic              irq
);
    logic at_end;
    assign at_end = (count == period);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= step && at_end && !load;
            if (load)        count <= load_val;
            else if (step)   count <= at_end ? '0 : count + DATA_W'(1);
        end
    end
endmodule

// File: rtl/gtmr16_top.sv
module gtmr16_top
    import gtmr16_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_EXT-1:0] ext_clk_en,
    input  logic               gate_in,
    input  logic               idle_in,
    output logic               irq_pulse,
    output logic               gate_done
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] period_q;
    logic [DATA_W-1:0] cnt_q;
    logic              gate_prev;
    logic              run_on, active, gated_mode;
    logic              wr_ctrl, wr_cnt, wr_block;
    logic              tick, ptick;

    assign run_on     = ctrl_q.run;
    assign active     = run_on && !(ctrl_q.idle_stop && idle_in);
    assign gated_mode = ctrl_q.gate_en && !ctrl_q.src_ext;
    assign wr_ctrl    = wr_en && (wr_addr == REG_CTRL);
    assign wr_cnt     = wr_en && (wr_addr == REG_COUNT);
    assign wr_block   = wr_ctrl || wr_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            period_q  <= '1;
            gate_prev <= 1'b0;
            gate_done <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data & CTRL_MASK);
            if (wr_en && wr_addr == REG_PERIOD) period_q <= wr_data;
            gate_prev <= gate_in;
            gate_done <= gate_prev && !gate_in && gated_mode && active;
        end
    end

    gtmr16_src src_i (
        .clk(clk), .rst(rst), .ext_in(ext_clk_en), .ext_sel(ctrl_q.ext_sel),
        .src_ext(ctrl_q.src_ext), .sync_en(ctrl_q.sync_en),
        .gate_en(ctrl_q.gate_en), .gate_in(gate_in), .tick(tick)
    );

    gtmr16_presc presc_i (
        .clk(clk), .rst(rst),
        .clr(wr_cnt || (wr_ctrl && run_on)),
        .adv(tick && active && !wr_block),
        .last(pre_last(ctrl_q.pre_sel)),
        .ptick(ptick)
    );

    gtmr16_cnt cnt_i (
        .clk(clk), .rst(rst), .load(wr_cnt), .load_val(wr_data),
        .step(ptick), .period(period_q), .count(cnt_q), .irq(irq_pulse)
    );

    always_comb begin
        case (rd_addr)
            REG_CTRL:   rd_data = ctrl_q;
            REG_COUNT:  rd_data = cnt_q;
            REG_PERIOD: rd_data = period_q;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gtmr16_chk.sv
module gtmr16_chk
    import gtmr16_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              gate_in,
    input logic              irq_pulse,
    input logic              gate_done,
    input logic              run,
    input logic [DATA_W-1:0] cnt
);
    assert_ctrl_unimpl_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == REG_CTRL) |-> ((rd_data & ~CTRL_MASK) == '0));

    assert_stopped_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (!run && !(wr_en && wr_addr == REG_COUNT)) |=> $stable(cnt));

    assert_gate_done_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
        gate_done |-> (!$past(gate_in) && $past(gate_in, 2)));

    assert_irq_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> (cnt == '0));

    assert_step_legal_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == REG_COUNT) |=>
        (cnt == $past(cnt) || cnt == $past(cnt) + 16'd1 || cnt == '0));

    assert_count_load_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == REG_COUNT) |=> (cnt == $past(wr_data)));
endmodule

bind gtmr16_top gtmr16_chk chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .gate_in(gate_in),
    .irq_pulse(irq_pulse), .gate_done(gate_done), .run(run_on), .cnt(cnt_q)
);

// File: tb/gtmr16_tb.sv
module gtmr16_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd1;
    logic [15:0] rd_data;
    logic [3:0]  ext_clk_en = 4'd0;
    logic        gate_in = 1'b0;
    logic        idle_in = 1'b0;
    logic        irq_pulse, gate_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    gtmr16_top dut_i (.*);

    always #2 clk = ~clk;

    // Behavioural reference model
    logic [15:0] m_ctrl, m_cnt, m_per;
    int          m_pc;
    logic        m_irq, m_gd, m_gp;
    logic [3:0]  a1, a2, a3;

    function automatic int ratio(input logic [1:0] s);
        case (s) 2'd0: return 1; 2'd1: return 8; 2'd2: return 64; default: return 256; endcase
    endfunction

    function automatic logic [15:0] m_rd(input logic [1:0] a);
        case (a) 2'd0: return m_ctrl; 2'd1: return m_cnt; 2'd2: return m_per; default: return 16'd0; endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_cnt = 0; m_per = 16'hFFFF; m_pc = 0;
            m_irq = 0; m_gd = 0; m_gp = 0; a1 = 0; a2 = 0; a3 = 0;
        end else begin
            automatic bit run   = m_ctrl[15];
            automatic bit act   = run && !(m_ctrl[13] && idle_in);
            automatic bit ext   = m_ctrl[1];
            automatic int e     = int'(m_ctrl[9:8]);
            automatic bit gen   = m_ctrl[7];
            automatic bit tk;
            automatic bit blk   = wr_en && (wr_addr == 2'd0 || wr_addr == 2'd1);
            automatic bit nirq  = 0;
            if (ext) tk = m_ctrl[2] ? (a2[e] && !a3[e]) : ext_clk_en[e];
            else     tk = gen ? gate_in : 1'b1;
            if (blk) begin
                if (wr_addr == 2'd0 && run) m_pc = 0;
                if (wr_addr == 2'd1) begin m_pc = 0; m_cnt = wr_data; end
            end else if (act && tk) begin
                m_pc++;
                if (m_pc == ratio(m_ctrl[5:4])) begin
                    m_pc = 0;
                    if (m_cnt == m_per) begin m_cnt = 0; nirq = 1; end
                    else m_cnt = m_cnt + 16'd1;
                end
            end
            m_gd = m_gp && !gate_in && gen && !ext && act;
            m_gp = gate_in;
            m_irq = nirq;
            if (wr_en && wr_addr == 2'd0) m_ctrl = wr_data & 16'hA3B6;
            if (wr_en && wr_addr == 2'd2) m_per = wr_data;
            a3 = a2; a2 = a1; a1 = ext_clk_en;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk({cur_req, " rd_data"}, rd_data, m_rd(rd_addr));
            chk({cur_req, " irq R9"}, {15'd0, irq_pulse}, {15'd0, m_irq});
            chk({cur_req, " gate_done R7"}, {15'd0, gate_done}, {15'd0, m_gd});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 0;
    endtask

    task automatic rnd_ext(input int n, input int sparse);
        for (int k = 0; k < n; k++) begin
            if (sparse != 0) begin
                if ($urandom_range(3) == 0) ext_clk_en[$urandom_range(3)] ^= 1'b1;
            end else ext_clk_en = 4'($urandom);
            if ($urandom_range(5) == 0) gate_in = ~gate_in;
            step(1);
        end
    endtask

    initial begin
        logic [15:0] held;
        step(3);
        rst = 0;
        step(1);
        cur_req = "R1";
        rd_addr = 0; @(negedge clk); chk("R1 ctrl", rd_data, 16'h0000);
        rd_addr = 2; @(negedge clk); chk("R1 period", rd_data, 16'hFFFF);
        rd_addr = 1; @(negedge clk); chk("R1 count", rd_data, 16'h0000);
        chk("R1 irq", {15'd0, irq_pulse}, 16'd0);
        step(1);

        cur_req = "R2";
        wr(0, 16'hFFFF);
        rd_addr = 0; @(negedge clk); chk("R2 ctrl mask", rd_data, 16'hA3B6);
        step(1);
        wr(0, 16'h0000);
        rd_addr = 3; @(negedge clk); chk("R2 addr3", rd_data, 16'h0000);
        step(1);
        rd_addr = 1;
        wr(1, 16'h0000);

        cur_req = "R4";
        wr(0, 16'h8000); step(20);
        @(negedge clk); chk("R4 internal count", rd_data, 16'd20);
        step(1);
        wr(0, 16'h0000); held = rd_data; step(10);
        @(negedge clk); chk("R4 stop holds", rd_data, held);
        step(1);

        cur_req = "R3";
        for (int s = 1; s < 4; s++) begin
            wr(1, 16'h0000);
            wr(0, 16'h8000 | 16'(s << 4));
            step(700);
        end
        wr(0, 16'h0000);

        cur_req = "R9";
        wr(2, 16'd5); wr(1, 16'd0); wr(0, 16'h8000); step(40);
        wr(2, 16'd0); step(10);
        wr(2, 16'd3); wr(0, 16'h8010); step(100);

        cur_req = "R8";
        wr(0, 16'h8004); step(30);

        cur_req = "R7";
        wr(2, 16'hFFFF); wr(0, 16'h8080); rnd_ext(300, 0);
        wr(0, 16'h8090); rnd_ext(300, 0);
        gate_in = 1; step(3); gate_in = 0; step(3);

        cur_req = "R5";
        for (int e = 0; e < 4; e++) begin
            wr(0, 16'h8082 | 16'(e << 8)); rnd_ext(150, 0);
        end

        cur_req = "R6";
        for (int e = 0; e < 4; e++) begin
            wr(0, 16'h8006 | 16'(e << 8)); rnd_ext(200, 1);
        end
        ext_clk_en = 0; step(4);

        cur_req = "R10";
        wr(0, 16'hA000);
        for (int k = 0; k < 120; k++) begin idle_in = (k % 7) < 3; step(1); end
        wr(0, 16'h8000);
        for (int k = 0; k < 120; k++) begin idle_in = (k % 5) < 2; step(1); end
        idle_in = 0;

        cur_req = "R11";
        wr(1, 16'h0100); wr(0, 16'h8010); step(5);
        wr(0, 16'h8010); held = rd_data;
        step(7); @(negedge clk); chk("R11 prescaler cleared", rd_data, held);
        step(1); @(negedge clk); chk("R11 count after clear", rd_data, held + 16'd1);
        step(3); wr(1, 16'h1234);
        @(negedge clk); chk("R11 count load", rd_data, 16'h1234);
        step(20);
        wr(0, 16'h0000); step(4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule